// File: doc/BRIEF.md
# E1 Receive Multiframe Descriptor Engine

This block sits behind an E1 framer on one receive channel and moves the received timeslot bytes into a shared data memory, one multiframe at a time. The framer side is abstracted as a byte strobe that carries the frame number (0..15) and the timeslot number (0..31) within the multiframe. It also carries a line-aligned flag and two CRC verdicts, one for each half of the multiframe. Software hands the engine empty memory regions by pushing descriptors that name a multiframe slot. At the first byte of each multiframe the engine takes the oldest such descriptor. It fills the 512-byte region at that slot and, after the last byte, returns a completed descriptor with the CRC verdicts.

Completed descriptors are read back through the same descriptor port. A read shows the oldest completed entry, with a valid flag, and a read strobe removes it. A control word enables the channel and picks one of four capture modes. A status word reports enable, line alignment, the fill state of both descriptor queues and a sticky overflow flag. The overflow flag rises when a multiframe begins and no empty descriptor is waiting.

Top module: `e1rx_bd_engine`

## Requirements
- R1: A control write sets the enable from bit 0 and the mode from bits [2:1]: 0 transparent, 1 byte aligned, 2 basic-frame aligned, 3 multiframe aligned. Status bit 0 reads back the enable.
- R2: The status word has these bits: 1 is the line-aligned input, 8 is input queue empty, 9 is input queue full, 10 is output queue empty, 11 is output queue full and 12 is overflow. All other bits read 0. After reset it reads 0x0500 while the aligned input is low.
- R3: A descriptor write queues the slot index held in bits [6:0] into a 4-entry input queue. A write while that queue holds 4 entries is dropped.
- R4: A byte with frame 0 and timeslot 0, accepted while enabled, starts a multiframe and takes the oldest queued slot. Each byte of that multiframe is written one cycle after its strobe, at address slot<<9 | frame<<5 | timeslot.
- R5: After the byte with frame 15 and timeslot 31, a completed descriptor enters the output queue in completion order. Its layout is: bit 15 set, bit 13 the CRC verdict of the first half, bit 14 that of the second half, bits [6:0] the slot. The CRC bits are reported only in mode 3 and read 0 in the other modes.
- R6: The descriptor read data shows the oldest completed descriptor, or 0 when none is pending. A read strobe removes it.
- R7: A multiframe start with an empty input queue sets the overflow flag. No byte of that multiframe is written and no descriptor is produced.
- R8: The overflow flag holds until a control write with bit 12 set. A new overflow in the same cycle as that write leaves the flag set.
- R9: In modes 2 and 3, a byte that arrives while the aligned input is low abandons the current multiframe. Its slot is consumed without a completed descriptor and no later byte of it is written. Modes 0 and 1 ignore the aligned input.
- R10: While disabled, bytes are neither written nor counted. Disabling in the middle of a multiframe abandons it.
- R11: Bytes that arrive outside a started multiframe are not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 16 | Control write data |
| csr_rdata | output | 16 | Status word |
| bd_wr | input | 1 | Empty descriptor push strobe |
| bd_wdata | input | 16 | Empty descriptor, slot in [6:0] |
| bd_rd | input | 1 | Completed descriptor pop strobe |
| bd_rdata | output | 16 | Oldest completed descriptor or 0 |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_ts | input | 5 | Timeslot of the byte |
| in_frame | input | 4 | Frame of the byte within the multiframe |
| in_aligned | input | 1 | Framer reports alignment |
| in_crc_ok | input | 2 | CRC verdicts of both halves, valid with the last byte |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 16 | Data memory byte address |
| mem_data | output | 8 | Data memory write byte |

## Verification
The checks on the output queue assume that software never has more than four descriptors outstanding at once, counting those queued, those being filled and those completed but unread, so a completion always finds room. The stimulus keeps this: it never pushes more than four descriptors before popping the completed ones. The checks also assume that the frame and timeslot numbers on the byte strobe count up in order within a multiframe. The stimulus always walks positions upward, from a chosen first byte to a chosen last one, with or without idle cycles between bytes.

// File: rtl/e1rx_pkg.sv
package e1rx_pkg;

   localparam int TS_W   = 5;
   localparam int FR_W   = 4;
   localparam int BYTE_W = 8;
   localparam int REG_W  = 16;

   // control word fields
   localparam int CTL_EN       = 0;
   localparam int CTL_MODE_LO  = 1;
   localparam int CTL_OVFL_CLR = 12;

   // status word fields
   localparam int ST_EN        = 0;
   localparam int ST_ALIGN     = 1;
   localparam int ST_IN_EMPTY  = 8;
   localparam int ST_IN_FULL   = 9;
   localparam int ST_OUT_EMPTY = 10;
   localparam int ST_OUT_FULL  = 11;
   localparam int ST_OVFL      = 12;

   // descriptor word fields
   localparam int BD_CRC0  = 13;
   localparam int BD_CRC1  = 14;
   localparam int BD_VALID = 15;

   typedef enum logic [1:0] {
      MODE_RAW   = 2'd0,
      MODE_OCTET = 2'd1,
      MODE_BASIC = 2'd2,
      MODE_MULTI = 2'd3
   } rx_mode_e;

endpackage

// File: rtl/e1rx_desc_fifo.sv
module e1rx_desc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("e1rx_desc_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("e1rx_desc_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  slots [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0] lvl_q;
   logic          do_push, do_pop;

   assign empty   = (lvl_q == '0);
   assign full    = (lvl_q == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = slots[rd_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         lvl_q <= lvl_q + CW'(do_push) - CW'(do_pop);
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= CW'(DEPTH)); // R3

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full && $stable(wr_q)); // R3

endmodule

// File: rtl/e1rx_mf_writer.sv
module e1rx_mf_writer
   import e1rx_pkg::*;
#(
   parameter int MF_W = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  rx_mode_e                    mode,
   input  logic                        in_valid,
   input  logic [BYTE_W-1:0]           in_data,
   input  logic [TS_W-1:0]             in_ts,
   input  logic [FR_W-1:0]             in_frame,
   input  logic                        in_aligned,
   input  logic [1:0]                  in_crc_ok,
   input  logic                        q_empty,
   input  logic [MF_W-1:0]             q_head,
   output logic                        q_pop,
   output logic                        done_push,
   output logic [REG_W-1:0]            done_desc,
   output logic                        ovfl_set,
   output logic                        mem_we,
   output logic [MF_W+FR_W+TS_W-1:0]   mem_addr,
   output logic [BYTE_W-1:0]           mem_data
);
   localparam int PAD_W = REG_W - 3 - MF_W;

   generate
      if (PAD_W < 0) begin : g_bad_mf
         $error("e1rx_mf_writer: MF_W too wide for the descriptor word");
      end
   endgenerate

   logic            active_q;
   logic [MF_W-1:0] mf_q;
   logic            is_first, is_last, needs_align, lost, take, opening, live;
   logic [MF_W-1:0] cur_mf;
   logic [1:0]      crc_rep;

   assign is_first    = (in_frame == '0) && (in_ts == '0);
   assign is_last     = (&in_frame) && (&in_ts);
   assign needs_align = (mode == MODE_BASIC) || (mode == MODE_MULTI);
   assign lost        = needs_align & ~in_aligned;
   assign take        = en & in_valid & ~lost;
   assign opening     = take & is_first;
   assign q_pop       = opening & ~q_empty;
   assign ovfl_set    = opening & q_empty;
   assign live        = take & (is_first ? ~q_empty : active_q);
   assign cur_mf      = is_first ? q_head : mf_q;
   assign crc_rep     = (mode == MODE_MULTI) ? in_crc_ok : 2'b00;
   assign done_push   = live & is_last;
   assign done_desc   = {1'b1, crc_rep[1], crc_rep[0], {PAD_W{1'b0}}, cur_mf};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         mf_q     <= '0;
      end else if (!en || (in_valid && lost)) begin
         active_q <= 1'b0;
      end else if (take) begin
         if (is_first)     active_q <= ~q_empty;
         else if (is_last) active_q <= 1'b0;
         if (q_pop) mf_q <= q_head;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
      end else begin
         mem_we   <= live;
         mem_addr <= {cur_mf, in_frame, in_ts};
         mem_data <= in_data;
      end
   end

   AST_ALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && in_valid && lost) |=> !mem_we); // R9

   AST_DISCARD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ovfl_set |=> !mem_we); // R7

endmodule

// File: rtl/e1rx_bd_engine.sv
module e1rx_bd_engine
   import e1rx_pkg::*;
#(
   parameter int MF_W   = 7,
   parameter int QDEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      csr_wr,
   input  logic [15:0]               csr_wdata,
   output logic [15:0]               csr_rdata,
   input  logic                      bd_wr,
   input  logic [15:0]               bd_wdata,
   input  logic                      bd_rd,
   output logic [15:0]               bd_rdata,
   input  logic                      in_valid,
   input  logic [7:0]                in_data,
   input  logic [4:0]                in_ts,
   input  logic [3:0]                in_frame,
   input  logic                      in_aligned,
   input  logic [1:0]                in_crc_ok,
   output logic                      mem_we,
   output logic [MF_W+8:0]           mem_addr,
   output logic [7:0]                mem_data
);
   localparam int AW = MF_W + FR_W + TS_W;

   generate
      if (AW != MF_W + 9) begin : g_bad_geom
         $error("e1rx_bd_engine: frame/timeslot widths disagree with port width");
      end
   endgenerate

   logic            en_q, ovfl_q;
   rx_mode_e        mode_q;
   logic            in_empty, in_full, out_empty, out_full;
   logic [MF_W-1:0] in_head;
   logic [REG_W-1:0] out_head, done_desc;
   logic            in_pop, done_push, ovfl_set, ovfl_clr;
   logic            unused_bits;

   assign unused_bits = ^{bd_wdata[15:MF_W], csr_wdata[15:13], csr_wdata[11:3]};
   assign ovfl_clr    = csr_wr & csr_wdata[CTL_OVFL_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= MODE_RAW;
         ovfl_q <= 1'b0;
      end else begin
         if (csr_wr) begin
            en_q   <= csr_wdata[CTL_EN];
            mode_q <= rx_mode_e'(csr_wdata[CTL_MODE_LO +: 2]);
         end
         if (ovfl_set)      ovfl_q <= 1'b1;
         else if (ovfl_clr) ovfl_q <= 1'b0;
      end
   end

   e1rx_desc_fifo #(.W(MF_W), .DEPTH(QDEPTH)) u_free_q (
      .clk(clk), .rst_n(rst_n),
      .push(bd_wr), .push_data(bd_wdata[MF_W-1:0]),
      .pop(in_pop), .head(in_head), .empty(in_empty), .full(in_full)
   );

   e1rx_desc_fifo #(.W(REG_W), .DEPTH(QDEPTH)) u_done_q (
      .clk(clk), .rst_n(rst_n),
      .push(done_push), .push_data(done_desc),
      .pop(bd_rd), .head(out_head), .empty(out_empty), .full(out_full)
   );

   e1rx_mf_writer #(.MF_W(MF_W)) u_writer (
      .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q),
      .in_valid(in_valid), .in_data(in_data), .in_ts(in_ts),
      .in_frame(in_frame), .in_aligned(in_aligned), .in_crc_ok(in_crc_ok),
      .q_empty(in_empty), .q_head(in_head), .q_pop(in_pop),
      .done_push(done_push), .done_desc(done_desc), .ovfl_set(ovfl_set),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   always_comb begin
      csr_rdata               = '0;
      csr_rdata[ST_EN]        = en_q;
      csr_rdata[ST_ALIGN]     = in_aligned;
      csr_rdata[ST_IN_EMPTY]  = in_empty;
      csr_rdata[ST_IN_FULL]   = in_full;
      csr_rdata[ST_OUT_EMPTY] = out_empty;
      csr_rdata[ST_OUT_FULL]  = out_full;
      csr_rdata[ST_OVFL]      = ovfl_q;
   end

   assign bd_rdata = out_empty ? '0 : out_head;

   AST_OUT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      done_push |-> !out_full); // R5

   AST_OVFL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfl_q && !ovfl_clr) |=> ovfl_q); // R8

   AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(en_q)); // R10

   AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      in_pop |-> !in_empty); // R4

endmodule

// File: tb/e1rx_bd_engine_bench.sv
`timescale 1ns/1ps
module e1rx_bd_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;
   logic        bd_wr = 1'b0;
   logic [15:0] bd_wdata = '0;
   logic        bd_rd = 1'b0;
   logic [15:0] bd_rdata;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic [4:0]  in_ts = '0;
   logic [3:0]  in_frame = '0;
   logic        in_aligned = 1'b0;
   logic [1:0]  in_crc_ok = '0;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data;

   always #2 clk = ~clk;

   e1rx_bd_engine u_e1rx_bd_engine (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .bd_wr(bd_wr), .bd_wdata(bd_wdata),
      .bd_rd(bd_rd), .bd_rdata(bd_rdata), .in_valid(in_valid),
      .in_data(in_data), .in_ts(in_ts), .in_frame(in_frame),
      .in_aligned(in_aligned), .in_crc_ok(in_crc_ok),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   int checks = 0;
   int errors = 0;
   int wr_count = 0;
   bit run_cmp = 1'b0;
   logic [7:0] dut_mem [int];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit          m_en, m_ovfl, m_active;
   logic [1:0]  m_mode;
   logic [6:0]  m_mf;
   logic [6:0]  inq[$];
   logic [15:0] outq[$];
   bit          e_we;
   logic [15:0] e_addr;
   logic [7:0]  e_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_ovfl = 0; m_active = 0; m_mode = 0; m_mf = 0;
         inq.delete(); outq.delete(); e_we = 0; e_addr = 0; e_data = 0;
      end else begin
         int isz;
         int osz;
         bit setf;
         isz = inq.size();
         osz = outq.size();
         setf = 0;
         e_we = 0;
         if (bd_rd && osz > 0) void'(outq.pop_front());
         if (!m_en) m_active = 0;
         else if (in_valid) begin
            if (m_mode >= 2 && !in_aligned) m_active = 0;
            else begin
               if (in_frame == 0 && in_ts == 0) begin
                  if (isz > 0) begin m_mf = inq.pop_front(); m_active = 1; end
                  else begin m_active = 0; setf = 1; end
               end
               if (m_active) begin
                  e_we = 1; e_addr = {m_mf, in_frame, in_ts}; e_data = in_data;
                  if (in_frame == 15 && in_ts == 31) begin
                     logic [1:0] c;
                     c = (m_mode == 3) ? in_crc_ok : 2'b00;
                     outq.push_back({1'b1, c[1], c[0], 6'd0, m_mf});
                     m_active = 0;
                  end
               end
            end
         end
         if (bd_wr && isz < 4) inq.push_back(bd_wdata[6:0]);
         if (csr_wr) begin
            m_en = csr_wdata[0]; m_mode = csr_wdata[2:1];
            if (csr_wdata[12]) m_ovfl = 0;
         end
         if (setf) m_ovfl = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         logic [15:0] est;
         est = '0;
         est[0] = m_en; est[1] = in_aligned;
         est[8] = (inq.size() == 0); est[9] = (inq.size() == 4);
         est[10] = (outq.size() == 0); est[11] = (outq.size() == 4);
         est[12] = m_ovfl;
         chk("R4 write enable", 32'(mem_we), 32'(e_we));
         if (e_we) begin
            chk("R4 write address", 32'(mem_addr), 32'(e_addr));
            chk("R4 write data", 32'(mem_data), 32'(e_data));
         end
         chk("R2 status word", 32'(csr_rdata), 32'(est));
         chk("R6 descriptor read", 32'(bd_rdata), outq.size() ? 32'(outq[0]) : 32'd0);
         if (mem_we) begin
            dut_mem[int'(mem_addr)] = mem_data;
            wr_count++;
         end
      end
   end

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 37 + i * 5) & 255);
   endfunction

   task automatic step();
      @(posedge clk); #1;
      csr_wr = 0; bd_wr = 0; bd_rd = 0; in_valid = 0;
   endtask

   task automatic csr_write(input logic [15:0] v);
      csr_wr = 1; csr_wdata = v; step();
   endtask

   task automatic push_bd(input logic [6:0] mf);
      bd_wr = 1; bd_wdata = {9'h1AB, mf}; step();
   endtask

   task automatic pop_bd();
      bd_rd = 1; step();
   endtask

   task automatic send_mf(input int seed, input int first, input int last, input bit gaps);
      for (int i = first; i <= last; i++) begin
         in_valid = 1; in_frame = i[8:5]; in_ts = i[4:0]; in_data = pat(seed, i);
         step();
         if (gaps) step();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      chk("R2 reset status", 32'(csr_rdata), 32'h0500);
      chk("R6 reset descriptor", 32'(bd_rdata), 32'h0);
      rst_n = 1; run_cmp = 1;
      step();

      // R1: enable in multiframe mode
      in_aligned = 1;
      csr_write(16'h0007);
      #1 chk("R1 enable readback", 32'(csr_rdata[0]), 32'h1);

      // R11: stray bytes with no started multiframe
      push_bd(7'd5);
      send_mf(1, 100, 110, 0);
      chk("R11 stray bytes not written", 32'(wr_count), 32'd0);
      push_bd(7'd9);

      // R4 R5: two multiframes, second with idle gaps
      in_crc_ok = 2'b11; send_mf(5, 0, 511, 0);
      in_crc_ok = 2'b01; send_mf(9, 0, 511, 1);
      chk("R5 first completion", 32'(bd_rdata), 32'hE005);
      pop_bd();
      chk("R5 second completion", 32'(bd_rdata), 32'hA009);
      pop_bd();
      chk("R6 empty after pops", 32'(bd_rdata), 32'h0);
      chk("R4 memory first byte", 32'(dut_mem.exists(5 << 9) ? dut_mem[5 << 9] : 8'hxx), 32'(pat(5, 0)));
      chk("R4 memory last byte", 32'(dut_mem[(5 << 9) | 511]), 32'(pat(5, 511)));
      chk("R4 memory mid byte", 32'(dut_mem[(9 << 9) | (7 << 5) | 3]), 32'(pat(9, 7 * 32 + 3)));

      // R7: start with empty input queue
      wr_count = 0;
      send_mf(3, 0, 511, 0);
      chk("R7 overflow raised", 32'(csr_rdata[12]), 32'h1);
      chk("R7 discarded multiframe not written", 32'(wr_count), 32'd0);
      chk("R7 no descriptor", 32'(bd_rdata), 32'h0);
      repeat (5) step();
      chk("R8 overflow sticky", 32'(csr_rdata[12]), 32'h1);
      csr_write(16'h1007);
      chk("R8 overflow cleared", 32'(csr_rdata[12]), 32'h0);
      // R8: new overflow in the clearing cycle wins
      csr_wr = 1; csr_wdata = 16'h1007;
      in_valid = 1; in_frame = 0; in_ts = 0; in_data = 8'h55;
      step();
      chk("R8 set beats clear", 32'(csr_rdata[12]), 32'h1);
      csr_write(16'h1007);

      // R3: fill input queue, fifth push dropped
      for (int k = 0; k < 5; k++) push_bd(7'(60 + k));
      chk("R3 input queue full", 32'(csr_rdata[9]), 32'h1);
      in_crc_ok = 2'b10;
      for (int k = 0; k < 4; k++) send_mf(60 + k, 0, 511, 0);
      chk("R2 output queue full", 32'(csr_rdata[11]), 32'h1);
      send_mf(70, 0, 511, 0);
      chk("R3 dropped push causes overflow", 32'(csr_rdata[12]), 32'h1);
      for (int k = 0; k < 4; k++) begin
         chk("R5 completion order", 32'(bd_rdata), 32'(16'hC000 | (60 + k)));
         pop_bd();
      end
      csr_write(16'h1007);

      // R9: alignment loss abandons multiframe
      push_bd(7'd20);
      in_crc_ok = 2'b11;
      send_mf(20, 0, 200, 0);
      in_aligned = 0;
      send_mf(20, 201, 511, 0);
      chk("R9 no completion after loss", 32'(bd_rdata), 32'h0);
      chk("R9 abandoned tail not written", 32'(dut_mem.exists((20 << 9) | 511)), 32'd0);
      in_aligned = 1;
      push_bd(7'd21);
      send_mf(21, 0, 511, 0);
      chk("R9 recovery completion", 32'(bd_rdata), 32'hE015);
      pop_bd();

      // R9 R5: transparent mode ignores alignment, reports no CRC
      csr_write(16'h0001);
      in_aligned = 0;
      push_bd(7'd30);
      send_mf(30, 0, 511, 1);
      chk("R9 transparent ignores alignment", 32'(bd_rdata), 32'h801E);
      pop_bd();

      // R5: basic-frame mode reports no CRC
      in_aligned = 1;
      csr_write(16'h0005);
      push_bd(7'd50);
      send_mf(50, 0, 511, 0);
      chk("R5 mode 2 CRC bits zero", 32'(bd_rdata), 32'h8032);
      pop_bd();

      // R10: disable mid multiframe
      csr_write(16'h0007);
      push_bd(7'd40);
      send_mf(40, 0, 100, 0);
      csr_write(16'h0006);
      wr_count = 0;
      send_mf(40, 101, 511, 0);
      chk("R10 disabled bytes not written", 32'(wr_count), 32'd0);
      csr_write(16'h0007);
      chk("R10 abandoned, no completion", 32'(bd_rdata), 32'h0);
      chk("R10 descriptor consumed", 32'(csr_rdata[8]), 32'h1);

      repeat (3) step();
      run_cmp = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule